// File: doc/BRIEF.md
# DMA Controller Register Bank and Interrupt Combiner

This block is the register interface of a multichannel DMA controller. It decodes a 4 KB window addressed in 32-bit words. For every channel it keeps five registers: source address, destination address, link pointer, control and configuration. Next to these it keeps a small global configuration field and the raw terminal-count and error interrupt flags. A fixed eight-byte identification block completes the window. The data-movement engine sits beside this block. It reads the per-channel enable bits, and it reports completions and failures as one-cycle pulses on `tc_set` and `err_set`.

Interrupt masking has no register of its own. Bit 15 of a channel's configuration register enables its terminal-count interrupt, and bit 14 enables its error interrupt. The single interrupt output goes high when any masked source is active. Software acknowledges a source by writing ones to a clear register.

Access uses a plain request port: `req_valid`, `req_write`, a byte address and write data. There is no back-pressure, so a request is accepted in the cycle it is presented. Read data returns on `rsp_rdata` with `rsp_valid` in the following cycle. The number of channels is set by the parameter `NCH`, which is either 8 or 2.

Top module: `dma_regbank`

## Requirements
- R1: Reset clears every channel register, the raw interrupt flags and the global configuration field. During and after reset, `irq`, `rsp_valid` and `chan_enable` are low.
- R2: A write stores the full word in a channel register. Channel registers sit at byte offset 0x100 + 0x20·c + 4·w, where c = addr[7:5] and w is 0 source, 1 destination, 2 link, 3 control, 4 configuration. A read request returns its data on `rsp_rdata` one cycle later with `rsp_valid` high, and `rsp_valid` is low in every other cycle.
- R3: For a channel index c ≥ NCH, reads return zero and writes change nothing. Words 5 to 7 inside a channel's slot also read as zero.
- R4: A pulse on bit c of `tc_set` sets raw terminal-count bit c, which reads at word 5 (0x014). A pulse on bit c of `err_set` sets raw error bit c, which reads at word 6 (0x018).
- R5: Writing to word 2 (0x008) clears each raw terminal-count bit whose write-data bit is 1. Writing to word 4 (0x010) does the same for the raw error bits. If a set pulse and a clear arrive in the same cycle, the set wins. Both clear words read as zero.
- R6: Word 1 (0x004) reads raw TC AND the configuration bit-15 vector. Word 3 (0x00C) reads raw error AND the configuration bit-14 vector. Word 0 (0x000) reads the OR of these two.
- R7: `irq` is high exactly when the combined masked status is nonzero.
- R8: Word 7 (0x01C) and the `chan_enable` output give the bitmap of channels whose configuration bit 0 is 1.
- R9: Word 12 (0x030) holds a 3-bit global configuration field in bits [2:0]. The higher bits read as zero.
- R10: Offsets 0xFE0 to 0xFFF return one identification byte per word, indexed by addr[4:2]. The bytes are 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1, except that the first byte is 0x81 when NCH is 2.
- R11: The software-request words 8 to 11 (0x020 to 0x02C), unused global words and the range 0x200 to 0xFDF read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte address in the window |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid (the cycle after a read) |
| rsp_rdata | output | DW | Read data |
| tc_set | input | NCH | Terminal-count event pulses from the engine |
| err_set | input | NCH | Error event pulses from the engine |
| chan_enable | output | NCH | Configuration bit 0 of each channel |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds two instances that share one request port. One has NCH = 8 and the other NCH = 2. The eight-channel instance covers the whole decode, including channel 7 and the interrupt masking. The two-channel instance shows that writes to channels 2 to 7 are dropped and that those channels read as zero. It also shows the changed first identification byte. Both instances are checked in the same cycles, so one stimulus stream compares the two channel counts directly.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  // global word indices (addr[7:2] with addr[11:8] == 0)
  localparam logic [5:0] GW_ALL      = 6'd0;
  localparam logic [5:0] GW_TC_MSK   = 6'd1;
  localparam logic [5:0] GW_TC_CLR   = 6'd2;
  localparam logic [5:0] GW_ER_MSK   = 6'd3;
  localparam logic [5:0] GW_ER_CLR   = 6'd4;
  localparam logic [5:0] GW_TC_RAW   = 6'd5;
  localparam logic [5:0] GW_ER_RAW   = 6'd6;
  localparam logic [5:0] GW_ENABLED  = 6'd7;
  localparam logic [5:0] GW_GCFG     = 6'd12;

  localparam int CHAN_WORDS = 5;   // registers per channel slot
  localparam int CFG_TC_IE  = 15;
  localparam int CFG_ER_IE  = 14;
  localparam int CFG_EN     = 0;
  localparam int GCFG_W     = 3;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
    case (idx)
      3'd0:    id_byte = (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dma_regbank_chans.sv
module dma_regbank_chans
  import dma_regbank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_chan,
  input  logic [2:0]    wr_word,
  input  logic [DW-1:0] wdata,
  input  logic [2:0]    rd_chan,
  input  logic [2:0]    rd_word,
  output logic [DW-1:0] rd_data,
  output logic [NCH-1:0] cfg_tc_ie,
  output logic [NCH-1:0] cfg_er_ie,
  output logic [NCH-1:0] cfg_en
);
  logic [DW-1:0] word_out [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [DW-1:0] regs_q [CHAN_WORDS];
    logic          sel;
    assign sel = wr_en && (wr_chan == 3'(c)) && (int'(wr_word) < CHAN_WORDS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < CHAN_WORDS; w++) regs_q[w] <= '0;
      end else if (sel) begin
        regs_q[wr_word] <= wdata;
      end
    end

    assign word_out[c]  = (int'(rd_word) < CHAN_WORDS) ? regs_q[rd_word] : '0;
    assign cfg_tc_ie[c] = regs_q[CHAN_WORDS-1][CFG_TC_IE];
    assign cfg_er_ie[c] = regs_q[CHAN_WORDS-1][CFG_ER_IE];
    assign cfg_en[c]    = regs_q[CHAN_WORDS-1][CFG_EN];
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_chan == 3'(c)) rd_data = word_out[c];
  end
endmodule

// File: rtl/dma_regbank_irq.sv
module dma_regbank_irq #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  input  logic           tc_clr_en,
  input  logic           err_clr_en,
  input  logic [NCH-1:0] clr_bits,
  input  logic [NCH-1:0] tc_ie,
  input  logic [NCH-1:0] er_ie,
  output logic [NCH-1:0] raw_tc,
  output logic [NCH-1:0] raw_err,
  output logic [NCH-1:0] tc_masked,
  output logic [NCH-1:0] err_masked,
  output logic           irq
);
  logic [NCH-1:0] tc_keep, err_keep;
  assign tc_keep  = tc_clr_en  ? ~clr_bits : '1;
  assign err_keep = err_clr_en ? ~clr_bits : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_tc  <= '0;
      raw_err <= '0;
    end else begin
      raw_tc  <= (raw_tc & tc_keep) | tc_set;     // set wins
      raw_err <= (raw_err & err_keep) | err_set;
    end
  end

  assign tc_masked  = raw_tc & tc_ie;
  assign err_masked = raw_err & er_ie;
  assign irq        = |(tc_masked | err_masked);
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [11:0]    req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  output logic [NCH-1:0] chan_enable,
  output logic           irq
);
  logic          wr, rd;
  logic          in_glob, in_chan, in_id;
  logic [5:0]    gword;
  logic [2:0]    cidx, cword;
  logic [GCFG_W-1:0] gcfg_q;
  logic [DW-1:0] chan_rd, rd_mux;
  logic [NCH-1:0] tc_ie, er_ie, raw_tc, raw_err, tc_masked, err_masked;
  logic          unused_addr;

  assign unused_addr = ^req_addr[1:0];
  assign wr      = req_valid && req_write;
  assign rd      = req_valid && !req_write;
  assign in_glob = (req_addr[11:8] == 4'h0);
  assign in_chan = (req_addr[11:8] == 4'h1);
  assign in_id   = (req_addr[11:5] == 7'h7F);
  assign gword   = req_addr[7:2];
  assign cidx    = req_addr[7:5];
  assign cword   = req_addr[4:2];

  dma_regbank_chans #(.NCH(NCH), .DW(DW)) u_chans (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr && in_chan), .wr_chan(cidx), .wr_word(cword), .wdata(req_wdata),
    .rd_chan(cidx), .rd_word(cword), .rd_data(chan_rd),
    .cfg_tc_ie(tc_ie), .cfg_er_ie(er_ie), .cfg_en(chan_enable)
  );

  dma_regbank_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .tc_set(tc_set), .err_set(err_set),
    .tc_clr_en(wr && in_glob && gword == GW_TC_CLR),
    .err_clr_en(wr && in_glob && gword == GW_ER_CLR),
    .clr_bits(req_wdata[NCH-1:0]),
    .tc_ie(tc_ie), .er_ie(er_ie),
    .raw_tc(raw_tc), .raw_err(raw_err),
    .tc_masked(tc_masked), .err_masked(err_masked), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  gcfg_q <= '0;
    else if (wr && in_glob && gword == GW_GCFG)  gcfg_q <= req_wdata[GCFG_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (in_chan) begin
      rd_mux = chan_rd;
    end else if (in_id) begin
      rd_mux = DW'(id_byte(cword, NCH));
    end else if (in_glob) begin
      case (gword)
        GW_ALL:     rd_mux = DW'(tc_masked | err_masked);
        GW_TC_MSK:  rd_mux = DW'(tc_masked);
        GW_ER_MSK:  rd_mux = DW'(err_masked);
        GW_TC_RAW:  rd_mux = DW'(raw_tc);
        GW_ER_RAW:  rd_mux = DW'(raw_err);
        GW_ENABLED: rd_mux = DW'(chan_enable);
        GW_GCFG:    rd_mux = DW'(gcfg_q);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_write,
  input logic [11:0]    req_addr,
  input logic [DW-1:0]  req_wdata,
  input logic [NCH-1:0] tc_set,
  input logic [NCH-1:0] err_set,
  input logic [NCH-1:0] raw_tc,
  input logic [NCH-1:0] raw_err,
  input logic           irq,
  input logic           rsp_valid
);
  logic tc_clr, er_clr, rd_req;
  logic unused_bits;
  assign unused_bits = ^{req_addr[1:0], req_wdata};
  assign rd_req = req_valid && !req_write;
  assign tc_clr = req_valid && req_write && req_addr[11:2] == 10'd2;
  assign er_clr = req_valid && req_write && req_addr[11:2] == 10'd4;

  a_r4_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_set) |=> ((raw_tc & $past(tc_set)) == $past(tc_set)));
  a_r4_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((raw_err & $past(err_set)) == $past(err_set)));
  a_r5_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_clr && tc_set == '0) |=> ((raw_tc & $past(req_wdata[NCH-1:0])) == '0));
  a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (er_clr && err_set == '0) |=> ((raw_err & $past(req_wdata[NCH-1:0])) == '0));
  a_r4_tc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set == '0 && !tc_clr) |=> $stable(raw_tc));
  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set == '0 && !er_clr) |=> $stable(raw_err));
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_tc | raw_err) != '0));
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  a_r2_rsp_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/dma_regbank_bench.sv
`timescale 1ns/1ps
module dma_regbank_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  tc8 = '0, er8 = '0;
  logic [1:0]  tc2 = '0, er2 = '0;
  logic        v8, v2, irq8, irq2;
  logic [31:0] d8, d2;
  logic [7:0]  en8;
  logic [1:0]  en2;
  logic [31:0] rd8, rd2;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  dma_regbank #(.NCH(8), .DW(32)) u_dma_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(v8), .rsp_rdata(d8),
    .tc_set(tc8), .err_set(er8), .chan_enable(en8), .irq(irq8));

  dma_regbank #(.NCH(2), .DW(32)) u_dma_regbank_n2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(v2), .rsp_rdata(d2),
    .tc_set(tc2), .err_set(er2), .chan_enable(en2), .irq(irq2));

  // {write, addr, wdata, expected read of the 8-channel instance}
  localparam int NV = 21;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h100, 32'h1111_1111, 32'h0},          // R2 ch0 source
    {1'b1, 12'h104, 32'h2222_2222, 32'h0},          // R2 ch0 destination
    {1'b1, 12'h1E8, 32'h3333_3333, 32'h0},          // R2 ch7 link
    {1'b1, 12'h16C, 32'h4444_4444, 32'h0},          // R2 ch3 control
    {1'b1, 12'h1B0, 32'h0000_C001, 32'h0},          // R2 ch5 config
    {1'b1, 12'h030, 32'hFFFF_FFFF, 32'h0},          // R9 global config
    {1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0},          // R11 soft request
    {1'b0, 12'h100, 32'h0, 32'h1111_1111},          // R2
    {1'b0, 12'h104, 32'h0, 32'h2222_2222},          // R2
    {1'b0, 12'h1E8, 32'h0, 32'h3333_3333},          // R2
    {1'b0, 12'h16C, 32'h0, 32'h4444_4444},          // R2
    {1'b0, 12'h1B0, 32'h0, 32'h0000_C001},          // R2
    {1'b0, 12'h114, 32'h0, 32'h0},                  // R3 word 5 of slot
    {1'b0, 12'h030, 32'h0, 32'h7},                  // R9
    {1'b0, 12'h020, 32'h0, 32'h0},                  // R11
    {1'b0, 12'h01C, 32'h0, 32'h20},                 // R8
    {1'b0, 12'h300, 32'h0, 32'h0},                  // R11 gap
    {1'b0, 12'hFE0, 32'h0, 32'h80},                 // R10
    {1'b0, 12'hFEC, 32'h0, 32'h0A},                 // R10
    {1'b0, 12'hFFC, 32'h0, 32'hB1},                 // R10
    {1'b0, 12'h0D0, 32'h0, 32'h0}                   // R11 undefined word
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    rd8 = d8; rd2 = d2;
    if (!v8) begin n_fail++; $display("FAIL R2 rsp_valid actual=0 expected=1"); end
  endtask

  task automatic pulse(input logic [7:0] t8, input logic [7:0] e8,
                       input logic [1:0] t2, input logic [1:0] e2);
    @(negedge clk);
    tc8 = t8; er8 = e8; tc2 = t2; er2 = e2;
    @(negedge clk);
    tc8 = '0; er8 = '0; tc2 = '0; er2 = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", 32'(irq8), 32'h0);
    check("R1 rsp_valid in reset", 32'(v8), 32'h0);
    check("R1 chan_enable in reset", 32'(en8), 32'h0);
    rst_n = 1'b1;
    rd(12'h014);
    check("R1 raw tc after reset", rd8, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64]);
        check($sformatf("R2/R3/R8-R11 table %0d", i), rd8, VEC[i][31:0]);
      end
    end

    @(negedge clk);
    check("R8 chan_enable 8ch", 32'(en8), 32'h20);
    check("R3 chan_enable 2ch ignores ch5", 32'(en2), 32'h0);
    check("R2 rsp_valid drops after read", 32'(v8), 32'h0);
    wr(12'h140, 32'h5A5A);
    rd(12'h140);
    check("R2 ch2 on 8ch", rd8, 32'h5A5A);
    check("R3 ch2 on 2ch reads zero", rd2, 32'h0);
    rd(12'h100);
    check("R2 ch0 on 2ch", rd2, 32'h1111_1111);
    rd(12'hFE0);
    check("R10 first id byte 2ch", rd2, 32'h81);

    pulse(8'h21, 8'h00, 2'b01, 2'b00);
    rd(12'h014);
    check("R4 raw tc 8ch", rd8, 32'h21);
    check("R4 raw tc 2ch", rd2, 32'h1);
    rd(12'h004);
    check("R6 masked tc", rd8, 32'h20);
    check("R7 irq high", 32'(irq8), 32'h1);
    check("R7 irq 2ch unmasked low", 32'(irq2), 32'h0);
    rd(12'h000);
    check("R6 combined", rd8, 32'h20);
    wr(12'h008, 32'h20);
    rd(12'h014);
    check("R5 tc clear", rd8, 32'h01);
    check("R7 irq after clear", 32'(irq8), 32'h0);
    rd(12'h008);
    check("R5 clear word reads zero", rd8, 32'h0);

    pulse(8'h00, 8'h01, 2'b00, 2'b00);
    rd(12'h018);
    check("R4 raw err", rd8, 32'h1);
    rd(12'h00C);
    check("R6 err unmasked", rd8, 32'h0);
    check("R7 irq err unmasked", 32'(irq8), 32'h0);
    wr(12'h110, 32'h4000);
    rd(12'h00C);
    check("R6 err masked", rd8, 32'h1);
    rd(12'h000);
    check("R6 combined err", rd8, 32'h1);
    check("R7 irq err", 32'(irq8), 32'h1);

    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h010; req_wdata = 32'h1; er8 = 8'h01;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; er8 = '0;
    rd(12'h018);
    check("R5 set wins over clear", rd8, 32'h1);
    wr(12'h010, 32'h1);
    rd(12'h018);
    check("R5 err clear", rd8, 32'h0);
    check("R7 irq low", 32'(irq8), 32'h0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 chan_enable on reset", 32'(en8), 32'h0);
    rst_n = 1'b1;
    rd(12'h1B0);
    check("R1 config cleared", rd8, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule